// File: doc/BRIEF.md
# Event-Counting Performance Monitor

This block counts hardware events for profiling. It has one cycle counter and two 32-bit event counters. The cycle counter can run at full rate or at 1/64 rate. Each event counter watches one line of a 256-wide vector of single-cycle event pulses. It picks that line with an 8-bit code held in the shared control word. Code 0xFF parks a counter, so it never advances.

A 32-bit counter that wraps past all-ones raises a sticky overflow flag. Each flag has its own interrupt enable, and an enabled flag drives a level interrupt. Software clears flags by writing the control word back with ones in the flag positions.

Software reaches the unit through a simple register port with four word addresses:
- 0: control word
- 1: cycle counter
- 2: event counter 0
- 3: event counter 1

A write takes effect at the clock edge where `reg_wr` is high. A read strobe `reg_rd` returns the register value in `rd_data` one cycle later, with `rd_valid` high. That value is the register contents before any update at the strobe edge. The port has no back-pressure: every strobe is served in one cycle.

Top module: `perf_mon_unit`

## Requirements
- R1: While control bit 0 (run) is 0, no counter changes except through a register write or a reset bit.
- R2: Writing control bit 1 as 1 zeroes both event counters, and writing bit 2 as 1 zeroes the cycle counter and its prescaler. Both bits read back as 0, and a reset takes priority over a counter write or increment in the same cycle.
- R3: With run set, the cycle counter advances on every cycle when control bit 3 is 0. When bit 3 is 1, it advances on every 64th enabled cycle, counted from its last reset.
- R4: Event counter 0 takes its event code from control bits 19:12, and event counter 1 takes its code from bits 27:20. With run set, a counter adds one in each cycle where `evt_pulse[code]` is high. Both codes reset to 0xFF.
- R5: A counter whose event code is 0xFF never increments, even when every event line is high.
- R6: The counter registers at addresses 1, 2 and 3 can be written and read back.
- R7: Each counter is 32 bits and wraps from 0xFFFFFFFF to 0. At that edge its overflow flag is set: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter.
- R8: Writing the control word with a 1 in a flag position clears that flag. A 0 in a flag position leaves the flag unchanged.
- R9: A flag is never lost. A new overflow in the same cycle as a clearing write leaves the flag set, and a flag already set stays set while other counters overflow.
- R10: `irq` is high exactly when some flag is set and its enable is also set. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R11: Control bits 7, 11 and 31:28 ignore writes and read as 0.
- R12: After reset, the control word reads 0x0FFFF000, all counters read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after reg_rd |
| evt_pulse | input | 256 | Event pulses indexed by event code |
| irq | output | 1 | Level interrupt |

## Verification
The in-module assertions watch several properties on every cycle:
- a parked or stopped counter holds its value;
- a counter moves by at most one per cycle and lands on zero after an overflow;
- a flag survives every cycle in which it is not explicitly cleared;
- an enabled overflow raises the interrupt.

Other properties only show up in the bench scenarios, where expected values are computed from the register map:
- exact counts under mixed event patterns;
- the divide-by-64 cycle rate;
- the set-beats-clear collision;
- the reset values and the masking of reserved bits.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W   = 32;
  localparam int CODE_W  = 8;
  localparam int N_EVT   = 1 << CODE_W;
  localparam int N_EC    = 2;
  localparam int N_FLAG  = N_EC + 1;
  localparam int PRE_W   = 6;

  localparam int B_RUN   = 0;
  localparam int B_ECRST = 1;
  localparam int B_CCRST = 2;
  localparam int B_SLOW  = 3;
  localparam int IE_LSB  = 4;
  localparam int FL_LSB  = 8;
  localparam int SEL_LSB = 12;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CYC  = 2'd1;
  localparam logic [1:0] A_EC0  = 2'd2;
  localparam logic [1:0] A_EC1  = 2'd3;
endpackage

// File: rtl/pmu_event_ctr.sv
module pmu_event_ctr #(
  parameter int W      = 32,
  parameter int CODE_W = 8,
  localparam int NEV   = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  input  logic [NEV-1:0]    events,
  input  logic              clr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      count,
  output logic              ovf
);
  logic inc;
  assign inc = run && (code != '1) && events[code];
  assign ovf = inc && !clr && !wr && (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (wr)  count <= wdata;
    else if (inc) count <= count + W'(1);
  end

  assert_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '1 && !clr && !wr) |=> $stable(count));
  assert_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !wr) |=> $stable(count));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr) |=> (count == $past(count) || count == $past(count) + W'(1)));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count == '0);
endmodule

// File: rtl/pmu_cycle_ctr.sv
module pmu_cycle_ctr #(
  parameter int W     = 32,
  parameter int PRE_W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         slow,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic         ovf
);
  logic [PRE_W-1:0] pre;
  logic             tick;
  assign tick = run && (!slow || pre == '1);
  assign ovf  = tick && !clr && !wr && (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre <= '0;
    else if (clr) pre <= '0;
    else if (run) pre <= pre + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (wr)   count <= wdata;
    else if (tick) count <= count + W'(1);
  end

  assert_cyc_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !wr) |=> $stable(count));
  assert_cyc_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && pre != '1 && !clr && !wr) |=> $stable(count));
  assert_cyc_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count == '0);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_rd,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  input  logic [N_EVT-1:0] evt_pulse,
  output logic             irq
);
  logic              run_q, slow_q;
  logic [N_FLAG-1:0] ie_q, flag_q, ovf_vec, w1c_mask, flag_keep;
  logic [CODE_W-1:0] code_q [N_EC];
  logic [CNT_W-1:0]  ec_cnt [N_EC];
  logic [CNT_W-1:0]  cyc_cnt;
  logic              ctrl_wr, ec_clr, cc_clr;
  logic [31:0]       ctrl_view, rd_mux;

  assign ctrl_wr   = reg_wr && reg_addr == A_CTRL;
  assign ec_clr    = ctrl_wr && reg_wdata[B_ECRST];
  assign cc_clr    = ctrl_wr && reg_wdata[B_CCRST];
  assign w1c_mask  = ctrl_wr ? reg_wdata[FL_LSB +: N_FLAG] : '0;
  assign flag_keep = flag_q & ~w1c_mask;

  generate
    for (genvar i = 0; i < N_EC; i++) begin : g_ec
      pmu_event_ctr #(.W(CNT_W), .CODE_W(CODE_W)) u_ec (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .code   (code_q[i]),
        .events (evt_pulse),
        .clr    (ec_clr),
        .wr     (reg_wr && reg_addr == 2'(A_EC0 + i)),
        .wdata  (reg_wdata),
        .count  (ec_cnt[i]),
        .ovf    (ovf_vec[i])
      );
    end
  endgenerate

  pmu_cycle_ctr #(.W(CNT_W), .PRE_W(PRE_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .slow  (slow_q),
    .clr   (cc_clr),
    .wr    (reg_wr && reg_addr == A_CYC),
    .wdata (reg_wdata),
    .count (cyc_cnt),
    .ovf   (ovf_vec[N_EC])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slow_q <= 1'b0;
      ie_q   <= '0;
      flag_q <= '0;
      for (int i = 0; i < N_EC; i++) code_q[i] <= '1;
    end else begin
      flag_q <= flag_keep | ovf_vec;
      if (ctrl_wr) begin
        run_q  <= reg_wdata[B_RUN];
        slow_q <= reg_wdata[B_SLOW];
        ie_q   <= reg_wdata[IE_LSB +: N_FLAG];
        for (int i = 0; i < N_EC; i++)
          code_q[i] <= reg_wdata[SEL_LSB + i*CODE_W +: CODE_W];
      end
    end
  end

  always_comb begin
    ctrl_view                      = '0;
    ctrl_view[B_RUN]               = run_q;
    ctrl_view[B_SLOW]              = slow_q;
    ctrl_view[IE_LSB +: N_FLAG]    = ie_q;
    ctrl_view[FL_LSB +: N_FLAG]    = flag_q;
    for (int i = 0; i < N_EC; i++)
      ctrl_view[SEL_LSB + i*CODE_W +: CODE_W] = code_q[i];
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_mux = ctrl_view;
      A_CYC:   rd_mux = cyc_cnt;
      A_EC0:   rd_mux = ec_cnt[0];
      default: rd_mux = ec_cnt[1];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= rd_mux;
    end
  end

  assign irq = |(flag_q & ie_q);

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_keep)) == $past(flag_keep)));
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_vec) |=> ((flag_q & $past(ovf_vec)) == $past(ovf_vec)));
  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ovf_vec & ie_q)) && !ctrl_wr) |=> irq);
  assert_rsv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[31:28] == 4'h0 || $past(reg_addr) != A_CTRL));
endmodule

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic         reg_rd = 1'b0;
  logic [31:0]  rd_data;
  logic         rd_valid;
  logic [255:0] evt_pulse = '0;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  perf_mon_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .rd_data(rd_data),
    .rd_valid(rd_valid), .evt_pulse(evt_pulse), .irq(irq)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rd_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s unexpected read act=%h exp=none", "R6", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s act=%h exp=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      evt_pulse = '0; evt_pulse[idx] = 1'b1;
    end
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq act=%b exp=%b", t, irq, e);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk_irq(1'b0, "R12");
        rd(2'd0, 32'h0FFF_F000, "R12");
        rd(2'd1, 32'h0, "R12");
        rd(2'd2, 32'h0, "R12");
        rd(2'd3, 32'h0, "R12");
        // R11 reserved bits dropped
        wr(2'd0, 32'hF070_5880);
        rd(2'd0, 32'h0070_5000, "R11");
        // R4 counting: run, codes 5 and 7
        wr(2'd0, 32'h0070_5001);
        pulse(5, 3);
        @(negedge clk); evt_pulse[5] = 1'b1; evt_pulse[7] = 1'b1;
        @(negedge clk); evt_pulse = '0;
        pulse(7, 1);
        wr(2'd0, 32'h0070_5000);
        rd(2'd2, 32'd4, "R4");
        rd(2'd3, 32'd2, "R4");
        // R1 stopped: pulses ignored
        pulse(5, 2);
        rd(2'd2, 32'd4, "R1");
        // R5 parked counter 0, counter 1 on code 7
        wr(2'd0, 32'h007F_F001);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk); evt_pulse = '1;
        end
        @(negedge clk); evt_pulse = '0;
        wr(2'd0, 32'h007F_F000);
        rd(2'd2, 32'd4, "R5");
        rd(2'd3, 32'd5, "R5");
        // R1/R3 full-rate cycle count: reset+run, 9 idle, stop => 11
        wr(2'd0, 32'h007F_F005);
        idle(9);
        wr(2'd0, 32'h007F_F000);
        rd(2'd1, 32'd11, "R3");
        // R2 event reset leaves cycle counter
        wr(2'd0, 32'h007F_F002);
        rd(2'd2, 32'd0, "R2");
        rd(2'd3, 32'd0, "R2");
        rd(2'd1, 32'd11, "R2");
        wr(2'd0, 32'h007F_F004);
        rd(2'd1, 32'd0, "R2");
        // R3 slow mode: 130 enabled edges => 2
        wr(2'd0, 32'h007F_F00D);
        idle(128);
        wr(2'd0, 32'h007F_F008);
        rd(2'd1, 32'd2, "R3");
        rd(2'd0, 32'h007F_F008, "R3");
        // R6 counter write/readback
        wr(2'd3, 32'h1234_5678);
        rd(2'd3, 32'h1234_5678, "R6");
        // R7 wrap of counter 0 with enable
        wr(2'd2, 32'hFFFF_FFFE);
        wr(2'd0, 32'h0FF0_3011);
        pulse(3, 2);
        chk_irq(1'b1, "R7");
        rd(2'd0, 32'h0FF0_3111, "R7");
        rd(2'd2, 32'h0, "R7");
        // R8 write 0 keeps, write 1 clears
        wr(2'd0, 32'h0FF0_3011);
        chk_irq(1'b1, "R8");
        wr(2'd0, 32'h0FF0_3111);
        chk_irq(1'b0, "R8");
        // R9 set beats clear in same edge
        wr(2'd0, 32'h0FF0_3000);
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, 32'h009F_F021);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 32'h009F_F221; reg_wr = 1'b1; evt_pulse[9] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0;
        chk_irq(1'b1, "R9");
        // R9 earlier flag kept while cycle counter overflows
        wr(2'd0, 32'h009F_F020);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h009F_F021);
        wr(2'd0, 32'h009F_F020);
        rd(2'd0, 32'h009F_F620, "R9");
        // R10 masked flag does not interrupt
        wr(2'd0, 32'h009F_F220);
        chk_irq(1'b0, "R10");
        rd(2'd0, 32'h009F_F420, "R10");
        idle(3);
        if (exp_q.size() != 0) begin
          n_bad++;
          $display("FAIL R6 pending reads act=%0d exp=0", exp_q.size());
        end
        done = 1'b1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog act=timeout exp=finish");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule